// File: doc/BRIEF.md
# Triggered Integration Window Generator

This block places a fixed-length detector integration window at a programmable distance after a run trigger. It runs on an 8 ns clock. The distance is built from two programmed counts: a fine count in clock ticks and a coarse count in blocks of 2^COARSE_LOG2 ticks. With the default of 128 ticks, a coarse block is 1.024 µs. Both counts are zero-based, so the hardware always uses the register value plus one. The moment the window opens, the block issues a single-cycle strobe that releases the amplifier reset. The window-active level rises on that same cycle and stays high for WIN_CYCLES cycles. The default of 5000 cycles gives 40 µs.

A second pair of counts, in the same two units, places a single-cycle acquisition-select pulse after the same run trigger. That pulse is legal only up to DAQ_LIMIT cycles after the trigger (62500 cycles, 500 µs, by default). A frame whose second delay exceeds the limit gets no pulse. Instead it raises a one-cycle range-error flag. A run trigger that arrives while an earlier frame is still busy is dropped, and a saturating counter records it. Busy means the window delay is counting, the window is open, or an acquisition pulse is still pending.

Top module: `trig_window_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, release_o, win_active_o, daq_trig_o and daq_err_o are 0 and overrun_cnt_o is 0.
- R2: A trigger is accepted on clock edge T0. Define D = (run_fine_i+1) + (run_coarse_i+1)·2^COARSE_LOG2. Then release_o is high for exactly one cycle, starting D edges after T0.
- R3: win_active_o rises on the same edge that raises release_o. It stays high for exactly WIN_CYCLES cycles.
- R4: All four delay inputs are captured on the accepted trigger edge. Later changes to them do not move the events of that frame.
- R5: Define Dq = (daq_fine_i+1) + (daq_coarse_i+1)·2^COARSE_LOG2. If Dq ≤ DAQ_LIMIT, daq_trig_o is high for exactly one cycle, starting Dq edges after T0. Dq = DAQ_LIMIT is still legal.
- R6: If Dq > DAQ_LIMIT, daq_err_o is high for exactly one cycle, starting on edge T0. No daq_trig_o pulse follows for that frame.
- R7: A rising trigger on an edge where the block is busy is ignored. It raises overrun_cnt_o by one, and the counter holds at its all-ones value. The block is busy from T0 up to and including the edge that closes the window. It stays busy until the edge that issues the pending acquisition pulse, whichever of the two is later.
- R8: A trigger held high for several cycles counts as one trigger, on its rising edge only.
- R9: A trigger on the first edge after the busy period ends is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 ns system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_trig_i | input | 1 | Run trigger, acted on at its rising edge |
| run_fine_i | input | FINE_W | Window delay, fine ticks, zero-based |
| run_coarse_i | input | COARSE_W | Window delay, coarse blocks, zero-based |
| daq_fine_i | input | FINE_W | Acquisition pulse delay, fine ticks, zero-based |
| daq_coarse_i | input | COARSE_W | Acquisition pulse delay, coarse blocks, zero-based |
| release_o | output | 1 | Amplifier-reset release strobe |
| win_active_o | output | 1 | Integration window open |
| daq_trig_o | output | 1 | Acquisition-select pulse |
| daq_err_o | output | 1 | Acquisition delay out of range |
| overrun_cnt_o | output | OVR_W | Saturating count of dropped triggers |

## Verification
The bench builds the block with COARSE_LOG2 = 3, WIN_CYCLES = 20, DAQ_LIMIT = 200 and OVR_W = 3. These values keep the fine and coarse sums to a few hundred cycles. That brings the exact legal limit and the first illegal value, 200 and 201, within reach. With a 3-bit counter, saturation of the dropped-trigger count is reached after a handful of pokes. The short window makes it cheap to aim triggers at the last busy edge and the first free edge.

// File: rtl/trig_window_gen.sv
module trig_window_gen #(
  parameter int FINE_W      = 32,
  parameter int COARSE_W    = 16,
  parameter int COARSE_LOG2 = 7,
  parameter int WIN_CYCLES  = 5000,
  parameter int DAQ_LIMIT   = 62500,
  parameter int OVR_W       = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_trig_i,
  input  logic [FINE_W-1:0]   run_fine_i,
  input  logic [COARSE_W-1:0] run_coarse_i,
  input  logic [FINE_W-1:0]   daq_fine_i,
  input  logic [COARSE_W-1:0] daq_coarse_i,
  output logic                release_o,
  output logic                win_active_o,
  output logic                daq_trig_o,
  output logic                daq_err_o,
  output logic [OVR_W-1:0]    overrun_cnt_o
);

  localparam int CSPAN_W = COARSE_W + COARSE_LOG2;
  localparam int SPAN_W  = ((FINE_W > CSPAN_W) ? FINE_W : CSPAN_W) + 2;
  localparam int WIN_W   = $clog2(WIN_CYCLES + 1);
  localparam logic [SPAN_W-1:0] ONE     = SPAN_W'(1);
  localparam logic [SPAN_W-1:0] DAQ_MAX = SPAN_W'(DAQ_LIMIT);
  localparam logic [WIN_W-1:0]  WIN_END = WIN_W'(WIN_CYCLES - 1);
  localparam logic [OVR_W-1:0]  OVR_SAT = '1;

  typedef enum logic [1:0] {S_IDLE, S_DELAY, S_OPEN} run_st_t;

  function automatic logic [SPAN_W-1:0] span(input logic [FINE_W-1:0] f,
                                             input logic [COARSE_W-1:0] c);
    return (SPAN_W'(f) + ONE) + ((SPAN_W'(c) + ONE) << COARSE_LOG2);
  endfunction

  run_st_t           st;
  logic              trig_q, daq_wait;
  logic [SPAN_W-1:0] run_left, daq_left;
  logic [WIN_W-1:0]  win_left;

  wire               trig_edge = run_trig_i & ~trig_q;
  wire               busy      = (st != S_IDLE) | daq_wait;
  wire               take      = trig_edge & ~busy;
  wire               reject    = trig_edge & busy;
  wire [SPAN_W-1:0]  run_span  = span(run_fine_i, run_coarse_i);
  wire [SPAN_W-1:0]  daq_span  = span(daq_fine_i, daq_coarse_i);
  wire               daq_ok    = daq_span <= DAQ_MAX;

  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= run_trig_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      run_left     <= '0;
      win_left     <= '0;
      release_o    <= 1'b0;
      win_active_o <= 1'b0;
    end else begin
      release_o <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          run_left <= run_span;
          st       <= S_DELAY;
        end
        S_DELAY: if (run_left == ONE) begin
          st           <= S_OPEN;
          release_o    <= 1'b1;
          win_active_o <= 1'b1;
          win_left     <= WIN_END;
        end else begin
          run_left <= run_left - ONE;
        end
        S_OPEN: if (win_left == '0) begin
          win_active_o <= 1'b0;
          st           <= S_IDLE;
        end else begin
          win_left <= win_left - WIN_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      daq_wait   <= 1'b0;
      daq_left   <= '0;
      daq_trig_o <= 1'b0;
      daq_err_o  <= 1'b0;
    end else begin
      daq_trig_o <= 1'b0;
      daq_err_o  <= 1'b0;
      if (take) begin
        if (daq_ok) begin
          daq_wait <= 1'b1;
          daq_left <= daq_span;
        end else begin
          daq_err_o <= 1'b1;
        end
      end else if (daq_wait) begin
        if (daq_left == ONE) begin
          daq_wait   <= 1'b0;
          daq_trig_o <= 1'b1;
        end else begin
          daq_left <= daq_left - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              overrun_cnt_o <= '0;
    else if (reject && overrun_cnt_o != OVR_SAT) overrun_cnt_o <= overrun_cnt_o + OVR_W'(1);
  end

endmodule

module trig_window_chk #(
  parameter int WIN_CYCLES = 5000,
  parameter int OVR_W      = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             release_o,
  input logic             win_active_o,
  input logic             daq_trig_o,
  input logic             daq_err_o,
  input logic [OVR_W-1:0] overrun_cnt_o
);

  int unsigned len_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            len_q <= 0;
    else if (win_active_o) len_q <= len_q + 1;
    else                   len_q <= 0;
  end

  // R2
  release_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |=> !release_o);

  // R3
  release_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |-> (win_active_o && !$past(win_active_o)));

  // R3
  rise_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_active_o) |-> release_o);

  // R3
  win_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win_active_o) |-> (len_q == WIN_CYCLES));

  // R5
  daq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    daq_trig_o |=> !daq_trig_o);

  // R6
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    daq_err_o |=> !daq_err_o);

  // R6
  err_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(daq_err_o && daq_trig_o));

  // R7
  ovr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_cnt_o - $past(overrun_cnt_o)) <= OVR_W'(1));

  // R7
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(overrun_cnt_o) == '1) |-> (overrun_cnt_o == '1));

endmodule

bind trig_window_gen trig_window_chk #(.WIN_CYCLES(WIN_CYCLES), .OVR_W(OVR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .release_o(release_o), .win_active_o(win_active_o),
  .daq_trig_o(daq_trig_o), .daq_err_o(daq_err_o), .overrun_cnt_o(overrun_cnt_o));

// File: tb/trig_window_gen_tb.sv
module trig_window_gen_tb_top;
  localparam int FW = 32, CW = 16, CL2 = 3, WIN = 20, LIM = 200, OW = 3;
  localparam int SAT = (1 << OW) - 1;

  logic clk = 0, rst_n = 0, run_trig_i = 0;
  logic [FW-1:0] run_fine_i = '0, daq_fine_i = '0;
  logic [CW-1:0] run_coarse_i = '0, daq_coarse_i = '0;
  logic release_o, win_active_o, daq_trig_o, daq_err_o;
  logic [OW-1:0] overrun_cnt_o;

  trig_window_gen #(.FINE_W(FW), .COARSE_W(CW), .COARSE_LOG2(CL2), .WIN_CYCLES(WIN),
                    .DAQ_LIMIT(LIM), .OVR_W(OW)) dut_i (.*);

  always #4 clk = ~clk;

  int cyc = 0, checks = 0, fails = 0, busy_end = 0, ovr_exp = 0;
  bit mon_en = 0, prev_act = 0;
  int rel_q[$], rise_q[$], fall_q[$], daq_q[$], err_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int span(int f, int c);
    return (f + 1) + (c + 1) * (1 << CL2);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: cycle %0d actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_en) begin
    if (rel_q.size() > 0 && rel_q[0] == cyc) begin
      chk(release_o, "R2 release", int'(release_o), 1); void'(rel_q.pop_front());
    end else if (release_o) chk(0, "R2 unexpected release", 1, 0);
    if (rise_q.size() > 0 && rise_q[0] == cyc) begin
      chk(win_active_o && !prev_act, "R3 window rise", int'(win_active_o), 1); void'(rise_q.pop_front());
    end else if (win_active_o && !prev_act) chk(0, "R3 unexpected rise", 1, 0);
    if (fall_q.size() > 0 && fall_q[0] == cyc) begin
      chk(!win_active_o && prev_act, "R3 window fall", int'(win_active_o), 0); void'(fall_q.pop_front());
    end else if (!win_active_o && prev_act) chk(0, "R3 unexpected fall", 0, 1);
    if (daq_q.size() > 0 && daq_q[0] == cyc) begin
      chk(daq_trig_o, "R5 daq pulse", int'(daq_trig_o), 1); void'(daq_q.pop_front());
    end else if (daq_trig_o) chk(0, "R5 unexpected daq pulse", 1, 0);
    if (err_q.size() > 0 && err_q[0] == cyc) begin
      chk(daq_err_o, "R6 range error", int'(daq_err_o), 1); void'(err_q.pop_front());
    end else if (daq_err_o) chk(0, "R6 unexpected error", 1, 0);
    prev_act = win_active_o;
  end

  task automatic go_at(input int t0);
    @(negedge clk);
    while (cyc < t0 - 1) @(negedge clk);
  endtask

  // Driver: pushes expected event cycles; R4 scrambles inputs after the trigger edge
  task automatic trig(input int f, input int c, input int df, input int dc, input int hold);
    int t0, d, dq;
    run_fine_i = FW'(f); run_coarse_i = CW'(c); daq_fine_i = FW'(df); daq_coarse_i = CW'(dc);
    run_trig_i = 1;
    t0 = cyc + 1; d = span(f, c); dq = span(df, dc);
    if (t0 > busy_end) begin
      rel_q.push_back(t0 + d); rise_q.push_back(t0 + d); fall_q.push_back(t0 + d + WIN);
      busy_end = t0 + d + WIN;
      if (dq <= LIM) begin
        daq_q.push_back(t0 + dq);
        if (t0 + dq > busy_end) busy_end = t0 + dq;
      end else err_q.push_back(t0);
    end else if (ovr_exp < SAT) ovr_exp++;
    @(negedge clk);
    chk(overrun_cnt_o == OW'(ovr_exp), "R7 overrun count", int'(overrun_cnt_o), ovr_exp);
    repeat (hold - 1) @(negedge clk);
    run_trig_i = 0;
    run_fine_i = FW'($urandom_range(0, 15)); run_coarse_i = CW'($urandom_range(0, 3));
    daq_fine_i = FW'($urandom_range(0, 15)); daq_coarse_i = CW'($urandom_range(0, 3));
  endtask

  task automatic r1_check;
    chk(!release_o && !win_active_o && !daq_trig_o && !daq_err_o && overrun_cnt_o == 0,
        "R1 reset state", int'({release_o, win_active_o, daq_trig_o, daq_err_o}) + int'(overrun_cnt_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: cycle %0d actual running expected done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    r1_check();
    rst_n = 1; mon_en = 1;
    @(negedge clk);
    r1_check();
    go_at(cyc + 3); trig(0, 0, 10, 5, 1);          // R2 R3 R5 basic frame
    go_at(busy_end + 3); trig(3, 1, 2, 0, 1);      // R4: inputs scrambled, pulse precedes window
    go_at(busy_end + 3); trig(7, 23, 7, 23, 1);    // R5 Dq exactly at the limit
    go_at(busy_end + 3); trig(0, 0, 8, 23, 1);     // R6 Dq one past the limit
    go_at(busy_end); trig(1, 1, 1, 1, 1);          // R7 poke on last busy edge
    go_at(busy_end + 3); trig(2, 0, 0, 0, 1);
    go_at(busy_end + 1); trig(0, 0, 0, 0, 1);      // R9 first free edge accepted
    go_at(busy_end + 3); trig(4, 2, 5, 1, 6);      // R8 held trigger
    chk(overrun_cnt_o == OW'(ovr_exp), "R8 held trigger count", int'(overrun_cnt_o), ovr_exp);
    go_at(busy_end + 3); trig(50, 10, 100, 5, 1);
    for (int i = 0; i < 9; i++) begin
      go_at(cyc + 2); trig(0, 0, 0, 0, 1);          // R7 saturation
    end
    go_at(busy_end + 5);
    chk(rel_q.size() + rise_q.size() + fall_q.size() + daq_q.size() + err_q.size() == 0,
        "R2 R3 R5 R6 pending events", rel_q.size() + daq_q.size() + err_q.size(), 0);
    chk(overrun_cnt_o == OW'(SAT), "R7 saturated count", int'(overrun_cnt_o), SAT);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule